// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block is the digital front end of a successive-approximation analog-to-digital converter. It produces the enable for the slow converter clock from the system clock. It also decides when a conversion begins, and it tracks how long that conversion runs. Software drives a small set of register-style controls: a converter enable, a write-one start request, an auto-trigger enable, a trigger-source select and a clock-divider select.

A conversion can start in two ways. Software can request one directly. When auto-triggering is on, a rising edge on the chosen trigger source also starts one. One of the selectable sources is the block's own end-of-conversion pulse, so choosing it makes the converter run continuously once software has started the first conversion. The conversion itself is modelled by a counter of converter clock ticks. While that counter runs, a busy flag is held high, and a one-cycle done pulse marks the end.

Top module: `adc_start_ctrl`

## Requirements
- R1: The divided clock enable `adc_tick_o` is high for one system cycle in every N cycles. N is set by `presc_sel_i`: codes 0 and 1 give N=2, and codes 2 to 7 give N=4, 8, 16, 32, 64, 128.
- R2: While `en_i` is low, the divider counter is held at zero and `adc_tick_o` stays low. After `en_i` rises, the first tick arrives after N-1 further clock edges.
- R3: With `en_i` high and the controller idle, a one-cycle `start_wr_i` produces a one-cycle `start_pulse_o` on the next cycle, and `busy_o` rises in that same cycle.
- R4: With `auto_en_i` high, a rising edge on the selected source starts a conversion. Codes 1 to 7 of `trig_sel_i` select `ext_trig_i[code-1]`. A source held high starts only one conversion.
- R5: Code 0 of `trig_sel_i` selects the block's own done pulse. Nothing starts until software writes the start request, and after that each done pulse starts the next conversion with no software action.
- R6: With auto-triggering on and the selected source idle, `start_wr_i` still starts a single conversion.
- R7: `busy_o` stays high until 25 divided ticks have passed for the first conversion after enabling, and until 13 ticks have passed for every later conversion.
- R8: `done_o` is high for exactly one cycle. That cycle immediately follows the cycle in which the final tick is counted, and `busy_o` is already low in it.
- R9: Start requests and trigger edges that arrive while `busy_o` is high are dropped and are not queued.
- R10: Clearing `en_i` aborts any running conversion. `busy_o` goes low and the next conversion counts as a first conversion again.
- R11: With `auto_en_i` low, edges on the selected source start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable; also releases the divider |
| start_wr_i | input | 1 | Software start request (write-one pulse) |
| auto_en_i | input | 1 | Auto-trigger enable |
| trig_sel_i | input | 3 | Trigger source select |
| presc_sel_i | input | 3 | Clock divider select |
| ext_trig_i | input | NUM_EXT | External trigger sources |
| adc_tick_o | output | 1 | Divided converter clock enable |
| start_pulse_o | output | 1 | One-cycle start to the sequencer |
| busy_o | output | 1 | Conversion in progress (start bit readback) |
| done_o | output | 1 | One-cycle conversion-complete flag |

## Verification
Every divider code is exercised with the converter re-enabled. This separates a divider that is released correctly on enable from one that keeps a stale count, and it separates codes 0 and 1 from the others. Trigger stimulus comes in several shapes: level toggles with auto-triggering off, a level held high, edges and software writes landing mid-conversion, and the self-trigger code before and after a software start. Together these tell edge detection apart from level sensing, dropping apart from queuing, and continuous running apart from a single shot. Disabling in mid-conversion, followed by a new start, shows whether the 25-tick first-conversion length is restored.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
    // Width of the divider select and trigger select fields
    localparam int SEL_W = 3;

    // Number of low divider bits that must be ones for a tick (code 0 aliases code 1)
    function automatic int unsigned div_exp(input logic [SEL_W-1:0] code);
        return (code == '0) ? 1 : int'(code);
    endfunction
endpackage

// File: rtl/adc_presc.sv
// Converter clock divider.
// A free-running counter that is held at zero while the converter is disabled.
// The tick fires when the low k bits of the counter are all ones, so the divide
// ratio is 2**k. Assumes the select value never asks for more bits than W.
module adc_presc
    import adc_start_pkg::*;
#(
    parameter int W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] mask;

    // Count while enabled; hold in reset otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // Build the low-bit mask for the selected divide ratio
    always_comb begin
        mask = '0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(div_exp(sel_i))) mask[i] = 1'b1;
        end
    end

    // Tick when all masked bits are set
    assign tick_o = en_i && ((cnt_q & mask) == mask);

    AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
endmodule

// File: rtl/adc_trig_edge.sv
// Trigger source selector and rising-edge detector.
// Code 0 selects the internal done pulse. Codes 1..NUM_EXT select the external
// bits. The selected level is registered every cycle, so a held level yields
// one edge and a pulsing source re-arms by itself.
module adc_trig_edge
    import adc_start_pkg::*;
#(
    parameter int NUM_EXT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               done_i,
    input  logic [NUM_EXT-1:0] ext_i,
    output logic               edge_o
);
    logic src;
    logic prev_q;

    // Multiplex the selected trigger source
    always_comb begin
        src = 1'b0;
        if (sel_i == '0) src = done_i;
        for (int k = 0; k < NUM_EXT; k++) begin
            if (sel_i == SEL_W'(k + 1)) src = ext_i[k];
        end
    end

    // Remember the previous level of the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src;
    end

    assign edge_o = src && !prev_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (!edge_o || sel_i != $past(sel_i))); // R4
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer model.
// Accepts a start request only when enabled and idle, then counts divided ticks
// until the conversion length is reached. The first conversion after enabling
// is longer. Requests that arrive while busy are dropped.
module adc_conv_seq #(
    parameter int CONV_TICKS  = 13,
    parameter int FIRST_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic req_i,
    output logic start_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(FIRST_TICKS);

    logic             busy_q;
    logic             first_q;
    logic             start_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Final tick index for the current conversion
    assign last = first_q ? CNT_W'(FIRST_TICKS - 1) : CNT_W'(CONV_TICKS - 1);

    // Accept starts, count ticks, flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            first_q <= 1'b1;
            start_q <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            if (!en_i) begin
                busy_q  <= 1'b0;
                first_q <= 1'b1;
                cnt_q   <= '0;
            end else if (busy_q) begin
                if (tick_i) begin
                    if (cnt_q == last) begin
                        busy_q  <= 1'b0;
                        first_q <= 1'b0;
                        done_q  <= 1'b1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else if (req_i) begin
                busy_q  <= 1'b1;
                start_q <= 1'b1;
                cnt_q   <= '0;
            end
        end
    end

    assign start_o = start_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q); // R3
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !start_q); // R9
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q))); // R8
endmodule

// File: rtl/adc_start_ctrl.sv
// Top of the conversion start controller.
// Combines the divider, the trigger edge detector and the sequencer. A start
// request is a software write or, with auto-triggering on, a source edge. The
// done pulse loops back as trigger source 0 for continuous conversion.
module adc_start_ctrl
    import adc_start_pkg::*;
#(
    parameter int NUM_EXT     = 7,
    parameter int PRESC_W     = 7,
    parameter int CONV_TICKS  = 13,
    parameter int FIRST_TICKS = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               start_wr_i,
    input  logic               auto_en_i,
    input  logic [SEL_W-1:0]   trig_sel_i,
    input  logic [SEL_W-1:0]   presc_sel_i,
    input  logic [NUM_EXT-1:0] ext_trig_i,
    output logic               adc_tick_o,
    output logic               start_pulse_o,
    output logic               busy_o,
    output logic               done_o
);
    logic tick;
    logic trig_edge;
    logic req;
    logic done;

    adc_presc #(.W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .sel_i  (presc_sel_i),
        .tick_o (tick)
    );

    adc_trig_edge #(.NUM_EXT(NUM_EXT)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (trig_sel_i),
        .done_i (done),
        .ext_i  (ext_trig_i),
        .edge_o (trig_edge)
    );

    // Merge software and hardware start requests
    assign req = start_wr_i || (auto_en_i && trig_edge);

    adc_conv_seq #(.CONV_TICKS(CONV_TICKS), .FIRST_TICKS(FIRST_TICKS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .tick_i  (tick),
        .req_i   (req),
        .start_o (start_pulse_o),
        .busy_o  (busy_o),
        .done_o  (done)
    );

    assign adc_tick_o = tick;
    assign done_o     = done;

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !busy_o); // R10
endmodule

// File: tb/adc_start_ctrl_tb.sv
module adc_start_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, start_wr = 1'b0, auto_en = 1'b0;
    logic [2:0] tsel = '0, psel = '0;
    logic [6:0] ext = '0;
    logic       tick_o, start_o, busy_o, done_o;

    int n_vec = 0, n_fail = 0, dut_starts = 0, dut_dones = 0;

    // reference model state
    int  m_pc = 0, m_tc = 0;
    bit  m_busy = 0, m_first = 1, m_prev = 0, m_sp = 0, m_dn = 0;

    always #2 clk = ~clk;

    adc_start_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .start_wr_i(start_wr),
        .auto_en_i(auto_en), .trig_sel_i(tsel), .presc_sel_i(psel),
        .ext_trig_i(ext), .adc_tick_o(tick_o), .start_pulse_o(start_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int mdiv();
        return 1 << ((psel == 0) ? 1 : int'(psel));
    endfunction

    function automatic bit mtick();
        return en && ((m_pc % mdiv()) == mdiv() - 1);
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_tc = 0; m_busy = 0; m_first = 1; m_prev = 0; m_sp = 0; m_dn = 0;
        end else begin
            bit t, src, edg;
            int len;
            t   = mtick();
            src = (tsel == 0) ? m_dn : ext[tsel-1];
            edg = src && !m_prev;
            m_prev = src;
            m_sp = 0;
            m_dn = 0;
            len = m_first ? 25 : 13;
            if (!en) begin
                m_pc = 0; m_busy = 0; m_tc = 0; m_first = 1;
            end else begin
                m_pc = (m_pc + 1) % 128;
                if (m_busy) begin
                    if (t) begin
                        if (m_tc == len - 1) begin
                            m_busy = 0; m_tc = 0; m_first = 0; m_dn = 1;
                        end else m_tc++;
                    end
                end else if (start_wr || (auto_en && edg)) begin
                    m_busy = 1; m_tc = 0; m_sp = 1;
                end
            end
        end
    end

    // compare every output once per cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (tick_o !== mtick()) begin
                n_fail++; $display("FAIL R1/R2 tick: actual %0b expected %0b", tick_o, mtick());
            end
            if (start_o !== m_sp) begin
                n_fail++; $display("FAIL R3 start: actual %0b expected %0b", start_o, m_sp);
            end
            if (busy_o !== m_busy) begin
                n_fail++; $display("FAIL R7 busy: actual %0b expected %0b", busy_o, m_busy);
            end
            if (done_o !== m_dn) begin
                n_fail++; $display("FAIL R8 done: actual %0b expected %0b", done_o, m_dn);
            end
            if (start_o) dut_starts++;
            if (done_o) dut_dones++;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic sw_start();
        start_wr = 1'b1; step(1); start_wr = 1'b0;
    endtask

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++; $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int base;
        step(3);
        // reset state
        check("R3 reset start", int'(start_o), 0);
        check("R7 reset busy", int'(busy_o), 0);
        check("R2 reset tick", int'(tick_o), 0);
        rst_n = 1'b1;
        step(5);
        check("R2 disabled tick", int'(tick_o), 0);

        // R3/R7: first and later software conversions
        en = 1'b1; psel = 3'd1; step(7);
        sw_start(); step(60);
        sw_start(); step(40);
        check("R7 two conversions done", dut_dones, 2);

        // R1/R2: every divider code after re-enable
        for (int c = 0; c < 8; c++) begin
            en = 1'b0; psel = 3'(c); step(2);
            en = 1'b1; step(300);
        end

        // R11: edges ignored with auto off
        psel = 3'd0; tsel = 3'd1; auto_en = 1'b0;
        base = dut_starts;
        repeat (6) begin ext[0] = ~ext[0]; step(3); end
        step(10);
        check("R11 no auto starts", dut_starts - base, 0);
        ext = '0;

        // R4: held level starts one conversion
        tsel = 3'd3; auto_en = 1'b1; step(2);
        base = dut_starts;
        ext[2] = 1'b1; step(120);
        check("R4 held level one start", dut_starts - base, 1);

        // R9: requests during busy are dropped
        ext[2] = 1'b0; step(2);
        base = dut_starts;
        ext[2] = 1'b1; step(4);
        repeat (4) begin ext[2] = 1'b0; step(1); ext[2] = 1'b1; step(1); sw_start(); end
        ext[2] = 1'b0;
        step(80);
        check("R9 single start", dut_starts - base, 1);

        // R5: self-trigger waits for software, then runs on
        tsel = 3'd0; step(2);
        base = dut_starts;
        step(60);
        check("R5 no start before software", dut_starts - base, 0);
        sw_start(); step(200);
        n_vec++;
        if (dut_starts - base < 5) begin
            n_fail++; $display("FAIL R5 continuous: actual %0d expected >=5", dut_starts - base);
        end
        auto_en = 1'b0; step(40);

        // R6: software start with auto on and source idle
        tsel = 3'd5; auto_en = 1'b1; step(2);
        base = dut_starts;
        sw_start(); step(40);
        check("R6 software start under auto", dut_starts - base, 1);

        // R10: abort mid-conversion, next one is a first conversion
        sw_start(); step(6);
        en = 1'b0; step(1);
        check("R10 busy cleared", int'(busy_o), 0);
        step(1); en = 1'b1; step(3);
        sw_start(); step(70);
        check("R10 restart completed", int'(busy_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule